// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Shifter

This block is a two-stage serializer. A holding register takes a snapshot of a parallel word whenever its capture strobe fires. A separate shift chain is then filled from that snapshot, either by a load request or by direct flow-through, and empties one bit per shift strobe onto a single serial output, most significant stage first. A serial input refills the chain at stage 0 as data moves toward the output. A new word can be captured while the previous word is still being shifted out.

All state runs on one fast system clock. The capture and shift "clocks" are single-cycle enable strobes that the user has already synchronized to that clock. Load and clear are active-low levels that are sampled on every system clock edge. They take effect without any shift strobe, so they override shifting. Clear only empties the shift chain and leaves the holding register untouched. Asserting load and clear together is not a legal request. The block gives that case a defined result: clear wins.

Top module: `bufsh_piso`

## Requirements
- R1: While `rst_n` is low, both registers are zero and `ser_out` reads 0.
- R2: On a clock edge where `cap_stb` is 1, the holding register takes `par_in`. Without `cap_stb`, changes on `par_in` have no effect on the holding register.
- R3: With `load_n` and `clr_n` both 1, an edge where `shf_stb` is 1 moves stage i into stage i+1 and loads `ser_in` into stage 0. Bit WIDTH-1 of the chain leaves first on `ser_out`.
- R4: With `clr_n` 1 and `load_n` 0, the chain takes the holding register contents on the next edge, whatever `shf_stb` is.
- R5: If `load_n` is 0 and `cap_stb` is 1 on the same edge, the chain takes the new `par_in` word on that edge (flow-through).
- R6: With `load_n` 1 and `clr_n` 0, the chain becomes all zeros on the next edge even if `shf_stb` is 1. The holding register keeps its value.
- R7: If `load_n` and `clr_n` are both 0, the chain is cleared. The holding register is unaffected.
- R8: With both controls inactive and no `shf_stb`, the chain holds its value and `ser_out` stays stable.
- R9: `ser_out` is always stage WIDTH-1 of the chain, registered and free of combinational input paths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of both registers |
| cap_stb | input | 1 | Capture strobe for the holding register |
| shf_stb | input | 1 | Shift strobe for the chain |
| par_in | input | WIDTH | Parallel data word |
| ser_in | input | 1 | Serial data entering stage 0 |
| load_n | input | 1 | Active-low load of the chain from the holding register |
| clr_n | input | 1 | Active-low clear of the chain |
| ser_out | output | 1 | Serial output, last chain stage |

## Verification
Every control and strobe is sampled on one rising edge. Its effect is visible on `ser_out` right after that same edge, so each result is due exactly one cycle after its stimulus. The bench applies all inputs on the falling edge, lets one rising edge pass, and compares at the following falling edge against a model that is advanced by the same single step. Chain contents that are not yet on the output are read back by shifting the whole word out. One bit is collected per cycle, most significant first, and the collected word is compared with the expected literal.

// File: rtl/bufsh_pkg.sv
package bufsh_pkg;

   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_CLEAR = 3'd1,
      OP_LOAD  = 3'd2,
      OP_FLOW  = 3'd3,
      OP_SHIFT = 3'd4
   } chain_op_e;

endpackage

// File: rtl/bufsh_ctrl.sv
module bufsh_ctrl
   import bufsh_pkg::*;
(
   input  logic      cap_stb,
   input  logic      shf_stb,
   input  logic      load_n,
   input  logic      clr_n,
   output chain_op_e op
);

   // priority: clear, then load (flow-through when a capture coincides), then shift
   always_comb begin
      if (!clr_n)
         op = OP_CLEAR;
      else if (!load_n)
         op = cap_stb ? OP_FLOW : OP_LOAD;
      else if (shf_stb)
         op = OP_SHIFT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/bufsh_store.sv
module bufsh_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_stb,
   input  logic [WIDTH-1:0] par_in,
   output logic [WIDTH-1:0] st_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= '0;
      else if (cap_stb)
         st_q <= par_in;
   end

endmodule

// File: rtl/bufsh_chain.sv
module bufsh_chain
   import bufsh_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chain_op_e        op,
   input  logic [WIDTH-1:0] st_q,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic [WIDTH-1:0] sh_q
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic below;
      logic nxt;

      if (i == 0) begin : g_head
         assign below = ser_in;
      end else begin : g_body
         assign below = sh_q[i-1];
      end

      always_comb begin
         unique case (op)
            OP_CLEAR: nxt = 1'b0;
            OP_LOAD:  nxt = st_q[i];
            OP_FLOW:  nxt = par_in[i];
            OP_SHIFT: nxt = below;
            default:  nxt = sh_q[i];
         endcase
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            sh_q[i] <= 1'b0;
         else
            sh_q[i] <= nxt;
      end
   end

endmodule

// File: rtl/bufsh_piso.sv
module bufsh_piso
   import bufsh_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_stb,
   input  logic             shf_stb,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             load_n,
   input  logic             clr_n,
   output logic             ser_out
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("bufsh_piso: WIDTH must be at least 2");
   end

   chain_op_e        op;
   logic [WIDTH-1:0] st_q;
   logic [WIDTH-1:0] sh_q;

   bufsh_ctrl u_ctrl (
      .cap_stb (cap_stb),
      .shf_stb (shf_stb),
      .load_n  (load_n),
      .clr_n   (clr_n),
      .op      (op)
   );

   bufsh_store #(.WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_stb (cap_stb),
      .par_in  (par_in),
      .st_q    (st_q)
   );

   bufsh_chain #(.WIDTH(WIDTH)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .st_q   (st_q),
      .par_in (par_in),
      .ser_in (ser_in),
      .sh_q   (sh_q)
   );

   assign ser_out = sh_q[MSB];

endmodule

// File: rtl/bufsh_piso_chk.sv
module bufsh_piso_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cap_stb,
   input logic         shf_stb,
   input logic [W-1:0] par_in,
   input logic         ser_in,
   input logic         load_n,
   input logic         clr_n,
   input logic         ser_out,
   input logic [W-1:0] st_q,
   input logic [W-1:0] sh_q
);

   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> st_q == $past(par_in)); // R2

   AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_stb |=> $stable(st_q)); // R2

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && shf_stb) |=> sh_q == {$past(sh_q[W-2:0]), $past(ser_in)}); // R3

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !load_n && !cap_stb) |=> sh_q == $past(st_q)); // R4

   AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !load_n && cap_stb) |=> sh_q == $past(par_in)); // R5

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n && load_n) |=> sh_q == '0); // R6

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n && !load_n) |=> sh_q == '0); // R7

   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && !shf_stb) |=> $stable(sh_q)); // R8

   AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && !shf_stb) |=> $stable(ser_out)); // R9

endmodule

bind bufsh_piso bufsh_piso_chk #(.W(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cap_stb (cap_stb),
   .shf_stb (shf_stb),
   .par_in  (par_in),
   .ser_in  (ser_in),
   .load_n  (load_n),
   .clr_n   (clr_n),
   .ser_out (ser_out),
   .st_q    (st_q),
   .sh_q    (sh_q)
);

// File: tb/tb_bufsh_piso.sv
module tb_bufsh_piso;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cap_stb, shf_stb, ser_in, load_n, clr_n;
   logic [W-1:0] par_in;
   logic         ser_out;

   logic [W-1:0] m_st, m_sh;
   int           n_chk = 0;
   int           n_bad = 0;

   always #5 clk = ~clk;

   bufsh_piso #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .shf_stb(shf_stb),
      .par_in(par_in), .ser_in(ser_in), .load_n(load_n), .clr_n(clr_n),
      .ser_out(ser_out)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one system cycle: drive at a falling edge, step the model, compare at the next falling edge
   task automatic tick(input string req, input logic cap, input logic shf, input logic [W-1:0] p,
                       input logic si, input logic ld, input logic cl);
      cap_stb = cap; shf_stb = shf; par_in = p; ser_in = si; load_n = ld; clr_n = cl;
      if (!rst_n)       begin m_sh = '0; m_st = '0; end
      else begin
         if (!cl)       m_sh = '0;
         else if (!ld)  m_sh = cap ? p : m_st;
         else if (shf)  m_sh = {m_sh[W-2:0], si};
         if (cap)       m_st = p;
      end
      @(posedge clk);
      @(negedge clk);
      check(req, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_sh[W-1]});
   endtask

   task automatic idle(input string req);
      tick(req, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
   endtask

   // shift the whole chain out, MSB first, and compare the collected word
   task automatic drain(input string req, input logic [W-1:0] exp);
      logic [W-1:0] got;
      for (int b = W - 1; b >= 0; b--) begin
         got[b] = ser_out;
         tick(req, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1);
      end
      check(req, got, exp);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      tick("R1", 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1);
      check("R1", {{(W-1){1'b0}}, ser_out}, '0);
      tick("R1", 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1);
      rst_n = 1'b1;
      tick("R1", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1); // load the reset storage
      drain("R1", 8'h00);
   endtask

   task automatic t_capture_load;
      tick("R2", 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1);
      tick("R4", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      drain("R3", 8'hA5);
   endtask

   task automatic t_store_ignores;
      tick("R2", 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1);
      tick("R2", 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1);
      drain("R2", 8'hA5);
   endtask

   task automatic t_serial_fill;
      logic [W-1:0] pat = 8'h3C;
      tick("R6", 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
      for (int b = W - 1; b >= 0; b--)
         tick("R3", 1'b0, 1'b1, 8'h00, pat[b], 1'b1, 1'b1);
      drain("R3", 8'h3C);
   endtask

   task automatic t_flow;
      tick("R5", 1'b1, 1'b0, 8'h69, 1'b0, 1'b0, 1'b1);
      check("R5", {{(W-1){1'b0}}, ser_out}, 8'h00);
      drain("R5", 8'h69);
   endtask

   task automatic t_load_over_shift;
      tick("R4", 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1);
      tick("R4", 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1);
      drain("R4", 8'h69);
   endtask

   task automatic t_clear;
      tick("R2", 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1);
      check("R6", {{(W-1){1'b0}}, ser_out}, 8'h01);
      tick("R6", 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
      drain("R6", 8'h00);
      tick("R6", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      drain("R6", 8'hFF);
   endtask

   task automatic t_illegal;
      tick("R7", 1'b1, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b1);
      tick("R7", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      check("R7", {{(W-1){1'b0}}, ser_out}, 8'h00);
      drain("R7", 8'h00);
      tick("R7", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      drain("R7", 8'hC3);
   endtask

   task automatic t_hold;
      tick("R8", 1'b1, 1'b0, 8'h81, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 5; k++) begin
         tick("R8", 1'b0, 1'b0, 8'h7E, 1'b1, 1'b1, 1'b1);
         check("R9", {{(W-1){1'b0}}, ser_out}, 8'h01);
      end
      drain("R8", 8'h81);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; cap_stb = 1'b0; shf_stb = 1'b0; par_in = '0;
      ser_in = 1'b0; load_n = 1'b1; clr_n = 1'b1;
      m_st = '0; m_sh = '0;
      @(negedge clk);
      t_reset();
      t_capture_load();
      t_store_ignores();
      t_serial_fill();
      t_flow();
      t_load_over_shift();
      t_clear();
      t_illegal();
      t_hold();
      idle("R8");
      finish_run();
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

endmodule